// File: doc/BRIEF.md
# Switching-Period Hysteresis Enable Controller

This block watches a train of power-cycle-detect strobes and decides, from the time between them, whether a secondary-side circuit such as a synchronous rectifier should be switched off to save standby power. Every interval between two strobes is measured in clock cycles. It is then sorted into one of three classes. A long period exceeds the disable threshold. A short period falls below the much smaller enable threshold. A middle period lies between the two.

The output `sec_disable` is active high and stands for the pull-down of an open-drain driver. It asserts only after a run of consecutive long periods. Once asserted, it releases after enough short periods have been collected in total, and the long or middle periods between them do not reset that total. Short periods seen while the output is still inactive are also kept, up to one less than the release count, so a later release can happen on the first short period. A wake-up event from the droop monitor is wired in but leaves this controller untouched. A low `supply_ok` holds the whole block in its power-up state.

Top module: `sgh_enable_ctrl`

## Requirements
- R1: After reset, and for the cycle after any cycle with `supply_ok` low, `sec_disable` is 0 and both period counts are zero.
- R2: The first `pcd_strobe` after reset or after `supply_ok` returns only starts the period timer and is not classified.
- R3: The period is the number of clock cycles between two sampled strobes. A period greater than `LONG_CYC` (177) is long. `sec_disable` rises on the edge that samples the `DIS_COUNT`-th (63rd) consecutive long period.
- R4: While `sec_disable` is 0, any classified period that is not long, including one of exactly `LONG_CYC`, clears the consecutive long count to zero.
- R5: A period less than `SHORT_CYC` (57) is short. While `sec_disable` is 1, it falls on the edge that samples the short period that brings the cumulative short count to `EN_COUNT` (32). Middle and long periods do not clear that count, and a period of exactly `SHORT_CYC` is not short.
- R6: Short periods seen while `sec_disable` is 0 add to the cumulative count, which is capped at `EN_COUNT`-1. The count is kept when `sec_disable` rises, so the release can come on the first short period afterwards.
- R7: The period timer saturates at 2^(ceil(log2(`LONG_CYC`+1))+1)-1 (511 by default) instead of wrapping, so an arbitrarily long gap counts as one long period.
- R8: `wake_evt` changes neither `sec_disable` nor either count.
- R9: `sec_disable` changes only on an edge that samples `pcd_strobe` high or `supply_ok` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all thresholds are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| supply_ok | input | 1 | Supply above its lockout level; low forces the power-up state |
| pcd_strobe | input | 1 | One-cycle power-cycle-detect strobe |
| wake_evt | input | 1 | Wake-up event flag; has no effect on this block |
| sec_disable | output | 1 | High disables the secondary circuit (pull-down active) |

## Verification
A consecutive count that clears wrongly or fails to clear moves the edge where `sec_disable` rises. The stimulus runs long periods up to the 62nd and then checks the output after every strobe, so a move of one period shows up on that strobe. A lost or extra cumulative short count moves the release by one strobe, or turns the immediate release after an assertion into a delayed one, and this shows on the next short period. A timer that wraps instead of saturating turns a 600-cycle gap into a middle period and holds off the expected assertion.

// File: rtl/sgh_pkg.sv
package sgh_pkg;

  typedef enum logic [1:0] {
    PC_MID   = 2'd0,
    PC_SHORT = 2'd1,
    PC_LONG  = 2'd2
  } per_class_t;

  function automatic int tmr_width(input int long_cyc);
    return $clog2(long_cyc + 1) + 1;
  endfunction

endpackage

// File: rtl/sgh_period_timer.sv
module sgh_period_timer
  import sgh_pkg::*;
#(
  parameter int LONG_CYC  = 177,
  parameter int SHORT_CYC = 57,
  parameter int TMR_W     = tmr_width(LONG_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             strobe,
  output per_class_t       cls,
  output logic             cls_vld,
  output logic [TMR_W-1:0] tmr_q
);

  localparam logic [TMR_W-1:0] TMR_MAX   = '1;
  localparam logic [TMR_W-1:0] LONG_LIM  = TMR_W'(LONG_CYC);
  localparam logic [TMR_W-1:0] SHORT_LIM = TMR_W'(SHORT_CYC);

  logic [TMR_W-1:0] tmr_d;
  logic             tmr_en;
  logic             arm_q, arm_d;

  always_comb begin
    tmr_en = 1'b0;
    tmr_d  = tmr_q;
    arm_d  = arm_q;
    if (!supply_ok) begin
      tmr_en = 1'b1;
      tmr_d  = '0;
      arm_d  = 1'b0;
    end else if (strobe) begin
      tmr_en = 1'b1;
      tmr_d  = TMR_W'(1);
      arm_d  = 1'b1;
    end else if (tmr_q != TMR_MAX) begin
      tmr_en = 1'b1;
      tmr_d  = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      arm_q <= 1'b0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
      arm_q <= arm_d;
    end
  end

  // Classification of the interval that ends with this strobe
  always_comb begin
    cls_vld = supply_ok & strobe & arm_q;
    if (tmr_q > LONG_LIM)       cls = PC_LONG;
    else if (tmr_q < SHORT_LIM) cls = PC_SHORT;
    else                        cls = PC_MID;
  end

endmodule

// File: rtl/sgh_hyst_fsm.sv
module sgh_hyst_fsm
  import sgh_pkg::*;
#(
  parameter int DIS_COUNT = 63,
  parameter int EN_COUNT  = 32,
  parameter int DIS_W     = $clog2(DIS_COUNT + 1),
  parameter int EN_W      = $clog2(EN_COUNT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  per_class_t      cls,
  input  logic            cls_vld,
  output logic            dis_q,
  output logic [DIS_W-1:0] dis_cnt_q,
  output logic [EN_W-1:0]  en_cnt_q
);

  localparam logic [DIS_W-1:0] DIS_LAST = DIS_W'(DIS_COUNT - 1);
  localparam logic [EN_W-1:0]  EN_LAST  = EN_W'(EN_COUNT - 1);

  logic             upd;
  logic             dis_d;
  logic [DIS_W-1:0] dis_cnt_d;
  logic [EN_W-1:0]  en_cnt_d;

  always_comb begin
    upd       = ~supply_ok | cls_vld;
    dis_d     = dis_q;
    dis_cnt_d = dis_cnt_q;
    en_cnt_d  = en_cnt_q;
    if (!supply_ok) begin
      dis_d     = 1'b0;
      dis_cnt_d = '0;
      en_cnt_d  = '0;
    end else if (cls_vld) begin
      if (!dis_q) begin
        // Consecutive long run toward disabling
        if (cls == PC_LONG) begin
          if (dis_cnt_q == DIS_LAST) begin
            dis_d     = 1'b1;
            dis_cnt_d = '0;
          end else begin
            dis_cnt_d = dis_cnt_q + 1'b1;
          end
        end else begin
          dis_cnt_d = '0;
        end
        // Short periods banked ahead of a later release
        if (cls == PC_SHORT && en_cnt_q < EN_LAST) begin
          en_cnt_d = en_cnt_q + 1'b1;
        end
      end else if (cls == PC_SHORT) begin
        if (en_cnt_q == EN_LAST) begin
          dis_d    = 1'b0;
          en_cnt_d = '0;
        end else begin
          en_cnt_d = en_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q     <= 1'b0;
      dis_cnt_q <= '0;
      en_cnt_q  <= '0;
    end else if (upd) begin
      dis_q     <= dis_d;
      dis_cnt_q <= dis_cnt_d;
      en_cnt_q  <= en_cnt_d;
    end
  end

endmodule

// File: rtl/sgh_enable_ctrl.sv
module sgh_enable_ctrl
  import sgh_pkg::*;
#(
  parameter int LONG_CYC  = 177,
  parameter int SHORT_CYC = 57,
  parameter int DIS_COUNT = 63,
  parameter int EN_COUNT  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic pcd_strobe,
  input  logic wake_evt,
  output logic sec_disable
);

  localparam int TMR_W = tmr_width(LONG_CYC);
  localparam int DIS_W = $clog2(DIS_COUNT + 1);
  localparam int EN_W  = $clog2(EN_COUNT + 1);

  per_class_t       cls;
  logic             cls_vld;
  logic [TMR_W-1:0] tmr_q;
  logic [DIS_W-1:0] dis_cnt;
  logic [EN_W-1:0]  en_cnt;

  sgh_period_timer #(
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC),
    .TMR_W    (TMR_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .strobe   (pcd_strobe),
    .cls      (cls),
    .cls_vld  (cls_vld),
    .tmr_q    (tmr_q)
  );

  sgh_hyst_fsm #(
    .DIS_COUNT(DIS_COUNT),
    .EN_COUNT (EN_COUNT),
    .DIS_W    (DIS_W),
    .EN_W     (EN_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .cls      (cls),
    .cls_vld  (cls_vld),
    .dis_q    (sec_disable),
    .dis_cnt_q(dis_cnt),
    .en_cnt_q (en_cnt)
  );

endmodule

// File: rtl/sgh_enable_ctrl_chk.sv
module sgh_enable_ctrl_chk
  import sgh_pkg::*;
#(
  parameter int LONG_CYC  = 177,
  parameter int DIS_COUNT = 63,
  parameter int EN_COUNT  = 32,
  parameter int TMR_W     = tmr_width(LONG_CYC),
  parameter int DIS_W     = $clog2(DIS_COUNT + 1),
  parameter int EN_W      = $clog2(EN_COUNT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_ok,
  input logic             pcd_strobe,
  input logic             wake_evt,
  input logic             sec_disable,
  input per_class_t       cls,
  input logic             cls_vld,
  input logic [TMR_W-1:0] tmr_q,
  input logic [DIS_W-1:0] dis_cnt,
  input logic [EN_W-1:0]  en_cnt
);

  localparam logic [TMR_W-1:0] TMR_MAX = '1;

  p_supply_low_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!sec_disable && dis_cnt == '0 && en_cnt == '0));

  p_rise_on_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_disable) |-> $past(cls_vld && cls == PC_LONG));

  p_not_long_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && cls_vld && cls != PC_LONG && !sec_disable) |=> dis_cnt == '0);

  p_fall_on_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sec_disable) && $past(supply_ok)) |-> $past(cls_vld && cls == PC_SHORT));

  p_bank_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_disable) |-> en_cnt == $past(en_cnt));

  p_timer_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == TMR_MAX && supply_ok && !pcd_strobe) |=> tmr_q == TMR_MAX);

  p_wake_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !pcd_strobe && supply_ok) |=>
      ($stable(sec_disable) && $stable(en_cnt) && $stable(dis_cnt)));

  p_change_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_disable != $past(sec_disable)) |-> $past(pcd_strobe || !supply_ok));

endmodule

bind sgh_enable_ctrl sgh_enable_ctrl_chk #(
  .LONG_CYC (LONG_CYC),
  .DIS_COUNT(DIS_COUNT),
  .EN_COUNT (EN_COUNT),
  .TMR_W    (TMR_W),
  .DIS_W    (DIS_W),
  .EN_W     (EN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .pcd_strobe (pcd_strobe),
  .wake_evt   (wake_evt),
  .sec_disable(sec_disable),
  .cls        (cls),
  .cls_vld    (cls_vld),
  .tmr_q      (tmr_q),
  .dis_cnt    (dis_cnt),
  .en_cnt     (en_cnt)
);

// File: tb/sim_sgh_enable_ctrl.sv
module sim_sgh_enable_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LONG_CYC   = 177;
  localparam int SHORT_CYC  = 57;
  localparam int DIS_COUNT  = 63;
  localparam int EN_COUNT   = 32;
  localparam int TMR_SAT    = (1 << ($clog2(LONG_CYC + 1) + 1)) - 1;
  localparam int WATCHDOG   = 190000;

  logic clk;
  logic rst_n;
  logic supply_ok;
  logic pcd_strobe;
  logic wake_evt;
  logic sec_disable;

  int n_chk;
  int n_bad;

  // Reference state, derived from the requirements
  bit m_arm;
  bit m_out;
  int m_dis;
  int m_en;

  sgh_enable_ctrl #(
    .LONG_CYC (LONG_CYC),
    .SHORT_CYC(SHORT_CYC),
    .DIS_COUNT(DIS_COUNT),
    .EN_COUNT (EN_COUNT)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .pcd_strobe (pcd_strobe),
    .wake_evt   (wake_evt),
    .sec_disable(sec_disable)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sec_disable actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mdl_reset();
    m_arm = 1'b0;
    m_out = 1'b0;
    m_dis = 0;
    m_en  = 0;
  endtask

  task automatic mdl_period(input int p);
    int  q;
    bit  is_long;
    bit  is_short;
    if (!m_arm) begin
      m_arm = 1'b1;
      return;
    end
    q        = (p > TMR_SAT) ? TMR_SAT : p;
    is_long  = q > LONG_CYC;
    is_short = q < SHORT_CYC;
    if (!m_out) begin
      if (is_long) begin
        m_dis++;
        if (m_dis == DIS_COUNT) begin
          m_out = 1'b1;
          m_dis = 0;
        end
      end else begin
        m_dis = 0;
      end
      if (is_short && m_en < EN_COUNT - 1) m_en++;
    end else if (is_short) begin
      m_en++;
      if (m_en == EN_COUNT) begin
        m_out = 1'b0;
        m_en  = 0;
      end
    end
  endtask

  // Strobe p cycles after the previous one; optional wake pulse in the gap
  task automatic send(input int p, input bit wk, input string req);
    for (int i = 1; i < p; i++) begin
      wake_evt = wk && (i == 1);
      @(posedge clk);
      #1;
    end
    wake_evt   = 1'b0;
    pcd_strobe = 1'b1;
    @(posedge clk);
    #1;
    pcd_strobe = 1'b0;
    mdl_period(p);
    chk(req, sec_disable, m_out);
  endtask

  task automatic supply_drop(input string req);
    supply_ok = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    mdl_reset();
    chk(req, sec_disable, 1'b0);
    supply_ok = 1'b1;
  endtask

  function automatic int rand_period();
    int b;
    b = int'($urandom_range(99, 0));
    if (b < 60)      return int'($urandom_range(400, LONG_CYC + 1));
    else if (b < 85) return int'($urandom_range(SHORT_CYC - 1, 2));
    else             return int'($urandom_range(LONG_CYC, SHORT_CYC));
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed       = $urandom(32'h5A17);
    n_chk      = 0;
    n_bad      = 0;
    rst_n      = 1'b0;
    supply_ok  = 1'b1;
    pcd_strobe = 1'b0;
    wake_evt   = 1'b0;
    mdl_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", sec_disable, 1'b0);
    @(posedge clk);
    #1;

    // R2: first strobe after a long wait is not counted as long
    send(300, 1'b0, "R2 first strobe");
    for (int i = 0; i < DIS_COUNT - 1; i++) send(200, 1'b0, "R2 unclassified first");
    chk("R2 still enabled after 62", sec_disable, 1'b0);
    // R3: 63rd consecutive long asserts
    send(LONG_CYC + 1, 1'b0, "R3 63rd long asserts");
    chk("R3 asserted", sec_disable, 1'b1);

    // R5: cumulative short count with long/mid periods between
    for (int i = 0; i < EN_COUNT - 1; i++) begin
      send(20, 1'b0, "R5 short accumulate");
      send((i % 2) ? 250 : SHORT_CYC, 1'b0, "R5 long/mid no clear");
    end
    chk("R5 held before 32nd short", sec_disable, 1'b1);
    send(SHORT_CYC - 1, 1'b0, "R5 32nd short releases");
    chk("R5 released", sec_disable, 1'b0);

    // R4: exactly LONG_CYC is not long and restarts the run
    for (int i = 0; i < DIS_COUNT - 1; i++) send(190, 1'b0, "R4 long run");
    send(LONG_CYC, 1'b0, "R4 boundary clears");
    for (int i = 0; i < DIS_COUNT - 1; i++) send(190, 1'b0, "R4 after clear");
    chk("R4 not yet asserted", sec_disable, 1'b0);
    send(190, 1'b0, "R4 asserts after fresh 63");
    chk("R4 asserted", sec_disable, 1'b1);

    // R5: a period of exactly SHORT_CYC never counts
    for (int i = 0; i < 40; i++) send(SHORT_CYC, 1'b0, "R5 boundary not short");
    chk("R5 boundary held", sec_disable, 1'b1);
    for (int i = 0; i < EN_COUNT; i++) send(30, 1'b0, "R5 release run");
    chk("R5 release after 32", sec_disable, 1'b0);

    // R6: banked shorts (capped) survive assertion, release is immediate
    for (int i = 0; i < 40; i++) send(10, 1'b0, "R6 bank while enabled");
    for (int i = 0; i < DIS_COUNT; i++) send(200, 1'b0, "R6 assert run");
    chk("R6 asserted", sec_disable, 1'b1);
    send(10, 1'b0, "R6 immediate release");
    chk("R6 released on first short", sec_disable, 1'b0);

    // R7: saturating timer
    for (int i = 0; i < DIS_COUNT - 1; i++) send(200, 1'b0, "R7 long run");
    send(TMR_SAT + 89, 1'b0, "R7 no wrap");
    chk("R7 wrap would be mid", sec_disable, 1'b1);
    supply_drop("R1 supply low");
    send(50, 1'b0, "R2 first after supply");
    for (int i = 0; i < DIS_COUNT - 1; i++) send(200, 1'b0, "R7 run");
    send(3000, 1'b0, "R7 very long gap");
    chk("R7 asserted by saturated gap", sec_disable, 1'b1);

    // R8: wake pulses during a release run change nothing
    for (int i = 0; i < EN_COUNT - 1; i++) send(25, 1'b1, "R8 wake ignored");
    chk("R8 held", sec_disable, 1'b1);
    send(25, 1'b1, "R8 release unaffected");
    chk("R8 released", sec_disable, 1'b0);

    // Random mix, R9 covered by per-strobe comparison
    for (int i = 0; i < 300; i++) begin
      send(rand_period(), ($urandom_range(3, 0) == 0), "R9 random");
      if (i == 150) supply_drop("R1 random supply low");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule